// File: doc/BRIEF.md
# Burst Quality Monitor

This block watches the health of a convolutional decoder one burst at a time. The decoder reports each path-metric normalization as a pulse. The monitor counts these pulses over a programmable window of clocks. At the close of every window it compares the count with a threshold. If the count reaches the threshold, it sets a sticky block-error flag. A high normalization rate means the decoder is not locked to the code, so a burst that was decoded in a bad phase raises the flag without any CRC or parity.

The monitor also estimates the channel error rate. It re-encodes the decoded bit stream with the rate-1/2, constraint-length-7 code. It then compares both regenerated code bits with the hard decisions of the received symbol pair, which the decoder supplies aligned with each decoded bit. The mismatches add up over the burst into a saturating 16-bit count. This count is published at each window boundary and at the end of the burst. The end-of-burst marker from the decoder output clears the flag, the counters and the encoder history, ready for the next burst.

A three-state controller tracks the burst. ST_IDLE means no burst is active. ST_MEASURE means a burst is active and bit errors are still being gathered. ST_FULL means a burst is active but the bit-error window has been used up. Transitions:
- ST_IDLE to ST_MEASURE on the first valid bit.
- ST_IDLE to ST_FULL instead on the first valid bit when the window setting is zero.
- ST_MEASURE to ST_FULL on the valid bit that completes the window.
- Any state to ST_IDLE on a valid bit carrying the stop marker.

Top module: `burst_quality_monitor`

## Requirements
- R1: After reset, `blk_err` is 0 and `ber_count` is 0.
- R2: While a burst is active, a window lasts `cfg_period`+1 clocks. In the clock after a window closes, `blk_err` is 1 if the number of `norm_pulse` cycles in that window (the closing clock included) is greater than or equal to `cfg_thresh`. A threshold of 0 therefore always flags.
- R3: Once set, `blk_err` stays 1 through later windows until a stop marker or reset.
- R4: A stop marker is `dec_stop` with `dec_valid`. In the next clock it clears `blk_err`, returns the controller to ST_IDLE, and restarts the window timer and the normalization count from zero.
- R5: Each valid bit is re-encoded over a 7-bit window whose bit 6 is the current bit and bit 0 is the bit six valid bits earlier. The two code bits are the XOR of the window ANDed with masks 1111001 and 1011011. The first is compared with `hard_i` and the second with `hard_q`. Each mismatch adds one error, and the encoder history is all zero at the start of every burst.
- R6: A mismatch in a position whose `erase_i` or `erase_q` is 1 is not counted.
- R7: `ber_count` changes only in the clock after a window closes or after a stop marker. It then takes the burst's running error total, including the errors of that clock.
- R8: Cycles with `dec_valid` low add no errors and do not advance the encoder history.
- R9: Only the first `cfg_ber_window`+1 valid bits of a burst contribute errors.
- R10: The error total saturates at 65535 instead of wrapping.
- R11: Outside a burst, the window timer and the normalization counter stay at rest, so `norm_pulse` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| norm_pulse | input | 1 | One-clock pulse per path-metric normalization |
| dec_bit | input | 1 | Decoded bit |
| dec_valid | input | 1 | Decoded bit is valid |
| dec_stop | input | 1 | Marks the last decoded bit of a burst |
| hard_i | input | 1 | Hard decision (sign) of the received first symbol |
| hard_q | input | 1 | Hard decision (sign) of the received second symbol |
| erase_i | input | 1 | First symbol was erased or punctured |
| erase_q | input | 1 | Second symbol was erased or punctured |
| cfg_period | input | 12 | Window length minus one, in clocks |
| cfg_thresh | input | 12 | Normalization count that flags a block error |
| cfg_ber_window | input | 16 | Number of counted bits per burst minus one |
| blk_err | output | 1 | Sticky block-error flag |
| ber_count | output | 16 | Published bit-error total of the burst |

## Verification
The threshold comparison is driven from a table of window lengths, thresholds and pulse counts. The table uses pulse counts one below and exactly at the threshold, so an off-by-one in the comparison or in the window length shows up as a wrong flag. It also includes a zero threshold and a one-clock window. Bit errors are injected on chosen positions of a varied bit pattern. These runs separate correct generator taps and history order from wrong ones, erased from unerased mismatches, and valid from invalid cycles. A short bit-error window and a run past 65535 errors expose a wrong window bound and counter wrap. A stop in the middle of a window, followed by a fresh burst, shows whether the timer and the normalization count really restart.

// File: rtl/bqm_pkg.sv
package bqm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_FULL    = 2'd2
    } bqm_state_e;

endpackage

// File: rtl/bqm_sat_counter.sv
module bqm_sat_counter #(
    parameter int W  = 12,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [IW-1:0] inc_i,
    output logic [W-1:0]  cnt_o,
    output logic [W-1:0]  nxt_o
);
    localparam int SW = W + 1;
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0]  cnt_q;
    logic [SW-1:0] sum;

    assign sum   = {1'b0, cnt_q} + SW'(inc_i);
    assign nxt_o = sum[W] ? TOP : sum[W-1:0];
    assign cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= nxt_o;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP)); // R10
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> (cnt_q >= $past(cnt_q))); // R10

endmodule

// File: rtl/bqm_period_timer.sv
module bqm_period_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         period_end_o
);
    logic [W-1:0] tmr_q;

    assign period_end_o = en_i && (tmr_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clr_i || period_end_o) begin
            tmr_q <= '0;
        end else if (en_i) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> (tmr_q == '0)); // R2
    AST_TIMER_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(tmr_q)); // R11

endmodule

// File: rtl/bqm_reencoder.sv
module bqm_reencoder #(
    parameter int         CLEN  = 7,
    parameter logic [6:0] GEN_A = 7'b1111001,
    parameter logic [6:0] GEN_B = 7'b1011011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       shift_i,
    input  logic       bit_i,
    input  logic       hard_i,
    input  logic       hard_q,
    input  logic       erase_i,
    input  logic       erase_q,
    output logic [1:0] nerr_o
);
    localparam int HW = CLEN - 1;

    logic [HW-1:0]   hist_q;
    logic [CLEN-1:0] win;
    logic            code_a;
    logic            code_b;
    logic            miss_a;
    logic            miss_b;

    assign win    = {bit_i, hist_q};
    assign code_a = ^(win & CLEN'(GEN_A));
    assign code_b = ^(win & CLEN'(GEN_B));
    assign miss_a = (code_a != hard_i) && !erase_i;
    assign miss_b = (code_b != hard_q) && !erase_q;
    assign nerr_o = {1'b0, miss_a} + {1'b0, miss_b};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr_i) begin
            hist_q <= '0;
        end else if (shift_i) begin
            hist_q <= win[CLEN-1:1];
        end
    end

    AST_ERASED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_i && erase_q) |-> (nerr_o == 2'd0)); // R6
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clr_i) |=> $stable(hist_q)); // R8

endmodule

// File: rtl/burst_quality_monitor.sv
module burst_quality_monitor
    import bqm_pkg::*;
#(
    parameter int         TW    = 12,
    parameter int         BW    = 16,
    parameter int         CLEN  = 7,
    parameter logic [6:0] GEN_A = 7'b1111001,
    parameter logic [6:0] GEN_B = 7'b1011011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          norm_pulse,
    input  logic          dec_bit,
    input  logic          dec_valid,
    input  logic          dec_stop,
    input  logic          hard_i,
    input  logic          hard_q,
    input  logic          erase_i,
    input  logic          erase_q,
    input  logic [TW-1:0] cfg_period,
    input  logic [TW-1:0] cfg_thresh,
    input  logic [BW-1:0] cfg_ber_window,
    output logic          blk_err,
    output logic [BW-1:0] ber_count
);
    localparam logic [BW-1:0] VMAX = '1;

    bqm_state_e state_q, state_d;

    logic          act;
    logic          stop;
    logic          win_open;
    logic          pe;
    logic [1:0]    nerr;
    logic [1:0]    err_inc;
    logic [TW-1:0] norm_cnt;
    logic [TW-1:0] norm_nxt;
    logic [BW-1:0] err_cnt;
    logic [BW-1:0] err_nxt;
    logic [BW-1:0] vcnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec_valid && !stop) begin
                    state_d = (cfg_ber_window == '0) ? ST_FULL : ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end else if (dec_valid && vcnt_q == cfg_ber_window) begin
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (stop) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // control outputs of the controller
    always_comb begin
        stop     = dec_stop && dec_valid;
        act      = (state_q != ST_IDLE) || dec_valid;
        win_open = (state_q != ST_FULL);
        err_inc  = (dec_valid && win_open) ? nerr : 2'd0;
    end

    bqm_period_timer #(.W(TW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (stop),
        .en_i         (act),
        .limit_i      (cfg_period),
        .period_end_o (pe)
    );

    bqm_sat_counter #(.W(TW), .IW(1)) u_norm_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (stop || pe),
        .en_i  (act),
        .inc_i (norm_pulse),
        .cnt_o (norm_cnt),
        .nxt_o (norm_nxt)
    );

    bqm_reencoder #(.CLEN(CLEN), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_reenc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (stop),
        .shift_i (dec_valid),
        .bit_i   (dec_bit),
        .hard_i  (hard_i),
        .hard_q  (hard_q),
        .erase_i (erase_i),
        .erase_q (erase_q),
        .nerr_o  (nerr)
    );

    bqm_sat_counter #(.W(BW), .IW(2)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (stop),
        .en_i  (act),
        .inc_i (err_inc),
        .cnt_o (err_cnt),
        .nxt_o (err_nxt)
    );

    // valid bits seen in the burst, for the bit-error window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt_q <= '0;
        end else if (stop) begin
            vcnt_q <= '0;
        end else if (dec_valid && win_open && vcnt_q != VMAX) begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    // published flag and error total
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_err   <= 1'b0;
            ber_count <= '0;
        end else if (stop) begin
            blk_err   <= 1'b0;
            ber_count <= err_nxt;
        end else if (pe) begin
            blk_err   <= blk_err || (norm_nxt >= cfg_thresh);
            ber_count <= err_nxt;
        end
    end

    AST_STOP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !blk_err); // R4
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state_q == ST_IDLE)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_err && !stop) |=> blk_err); // R3
    AST_BER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !pe) |=> $stable(ber_count)); // R7
    AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !stop) |=> $stable(err_cnt)); // R9
    AST_NORM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (norm_cnt == '0)); // R11

endmodule

// File: tb/test_burst_quality_monitor.sv
`timescale 1ns/1ps
module test_burst_quality_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        norm_pulse = 1'b0;
    logic        dec_bit = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_stop = 1'b0;
    logic        hard_i = 1'b0;
    logic        hard_q = 1'b0;
    logic        erase_i = 1'b0;
    logic        erase_q = 1'b0;
    logic [11:0] cfg_period = 12'd0;
    logic [11:0] cfg_thresh = 12'd0;
    logic [15:0] cfg_ber_window = 16'hFFFF;
    logic        blk_err;
    logic [15:0] ber_count;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [5:0] prev = 6'd0;

    localparam logic [6:0] MASK_A = 7'b1111001;
    localparam logic [6:0] MASK_B = 7'b1011011;

    // {period, threshold, pulses, expected flag}
    localparam logic [36:0] VEC [0:7] = '{
        {12'd179,  12'd17,  12'd17,  1'b1},
        {12'd179,  12'd17,  12'd16,  1'b0},
        {12'd2047, 12'd180, 12'd180, 1'b1},
        {12'd2047, 12'd180, 12'd179, 1'b0},
        {12'd55,   12'd6,   12'd6,   1'b1},
        {12'd55,   12'd6,   12'd5,   1'b0},
        {12'd9,    12'd0,   12'd0,   1'b1},
        {12'd0,    12'd1,   12'd1,   1'b1}
    };

    always #2.5 clk = ~clk;

    burst_quality_monitor i_burst_quality_monitor (
        .clk            (clk),
        .rst_n          (rst_n),
        .norm_pulse     (norm_pulse),
        .dec_bit        (dec_bit),
        .dec_valid      (dec_valid),
        .dec_stop       (dec_stop),
        .hard_i         (hard_i),
        .hard_q         (hard_q),
        .erase_i        (erase_i),
        .erase_q        (erase_q),
        .cfg_period     (cfg_period),
        .cfg_thresh     (cfg_thresh),
        .cfg_ber_window (cfg_ber_window),
        .blk_err        (blk_err),
        .ber_count      (ber_count)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // drive one clock cycle, starting and ending at a falling edge
    task automatic tick(input logic v, input logic b, input logic hi, input logic hq,
                        input logic ei, input logic eq, input logic np, input logic st);
        dec_valid  = v;
        dec_bit    = b;
        hard_i     = hi;
        hard_q     = hq;
        erase_i    = ei;
        erase_q    = eq;
        norm_pulse = np;
        dec_stop   = st;
        @(negedge clk);
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // one valid bit with hard decisions from the code, optionally flipped
    task automatic send(input logic b, input logic fi, input logic fq,
                        input logic ei, input logic eq, input logic st);
        logic [6:0] w;
        logic ca;
        logic cb;
        w  = {b, prev};
        ca = ^(w & MASK_A);
        cb = ^(w & MASK_B);
        tick(1'b1, b, ca ^ fi, cb ^ fq, ei, eq, 1'b0, st);
        prev = st ? 6'd0 : w[6:1];
    endtask

    initial begin
        logic [15:0] held;
        logic [15:0] pat;
        repeat (3) @(negedge clk);
        check("R1 blk_err in reset", int'(blk_err), 0);
        rst_n = 1'b1;
        idle();
        check("R1 blk_err after reset", int'(blk_err), 0);
        check("R1 ber_count after reset", int'(ber_count), 0);

        // table of threshold cases: R2 and R3
        for (int k = 0; k < 8; k++) begin
            logic [11:0] tp;
            logic [11:0] np;
            logic        ex;
            tp = VEC[k][36:25];
            np = VEC[k][12:1];
            ex = VEC[k][0];
            cfg_period = tp;
            cfg_thresh = VEC[k][24:13];
            idle();
            for (int c = 0; c <= int'(tp); c++) begin
                tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, (c < int'(np)), 1'b0);
            end
            check($sformatf("R2 vector %0d flag", k), int'(blk_err), int'(ex));
            for (int c = 0; c <= int'(tp); c++) begin
                tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            end
            check($sformatf("R3 vector %0d flag after quiet window", k), int'(blk_err), int'(ex));
            tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            check($sformatf("R4 vector %0d flag cleared by stop", k), int'(blk_err), 0);
            idle();
        end

        // R4: stop mid-window restarts timer and normalization count
        cfg_period = 12'd19;
        cfg_thresh = 12'd5;
        for (int c = 0; c < 3; c++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int c = 0; c < 20; c++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, (c < 2), 1'b0);
        check("R4 count restarted after stop", int'(blk_err), 0);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle();

        // R5 and R7: errors on chosen positions, window of 16 clocks
        cfg_period = 12'd15;
        cfg_thresh = 12'd4095;
        cfg_ber_window = 16'hFFFF;
        prev = 6'd0;
        pat  = 16'hB5C3;
        held = ber_count;
        for (int c = 0; c < 16; c++) begin
            send(pat[c], (c == 3) || (c == 9), (c == 5) || (c == 9), 1'b0, 1'b0, 1'b0);
            if (c == 10) check("R7 ber_count held mid-window", int'(ber_count), int'(held));
        end
        check("R5 errors published at window end", int'(ber_count), 4);
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 final total published at stop", int'(ber_count), 5);
        idle();

        // R6: erased mismatches are skipped
        cfg_period = 12'd4095;
        pat = 16'h3A6D;
        for (int c = 0; c < 8; c++) begin
            send(pat[c], 1'b1, (c == 2) || (c == 6), (c < 4), (c == 2), 1'b0);
        end
        send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 erased positions not counted", int'(ber_count), 5);
        idle();

        // R8: invalid cycles neither count nor shift history
        pat = 16'h00E9;
        for (int c = 0; c < 6; c++) begin
            send(pat[c], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        send(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 invalid cycles ignored", int'(ber_count), 2);
        idle();

        // R9: only the first window+1 valid bits count
        cfg_ber_window = 16'd3;
        for (int c = 0; c < 8; c++) send(c[0], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R9 bit-error window bound", int'(ber_count), 8);
        idle();

        // R10: saturation at 65535
        cfg_ber_window = 16'hFFFF;
        for (int c = 0; c < 33000; c++) send(c[1], 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10 error total saturates", int'(ber_count), 65535);
        idle();

        // R11: normalization pulses outside a burst are ignored
        cfg_period = 12'd9;
        cfg_thresh = 12'd1;
        held = ber_count;
        for (int c = 0; c < 50; c++) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R11 flag quiet while idle", int'(blk_err), 0);
        check("R11 ber_count held while idle", int'(ber_count), int'(held));
        for (int c = 0; c < 10; c++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 idle pulses not carried into burst", int'(blk_err), 0);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule